// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block is the central arbiter of a shared parallel bus that several masters drive. Each master has a request line into the arbiter and a grant line back from it, and a master drives the bus only while its grant is asserted. At most one grant is asserted at any time. When no other master wants the bus, the grant stays on the master that held it last. That master can then start one transaction after another with no arbitration delay.

When another master asks for the bus, the arbiter picks the next owner in round-robin order while the current transfer is still in progress. In the same edge it removes the current grant, which tells the owner to end its burst. The winner is stored at that point. Its grant is raised only after the arbiter sees an idle bus, meaning that the frame and initiator-ready signals are both deasserted. A grant change is made as two steps: the old grant falls on one edge and the new grant rises on a later edge. Because of this, no clock ever changes more than one grant line.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset the grant vector is parked on master 0: bit 0 is high and all other bits are low. Bit i of `gnt` and of `req` belongs to master i, and all signals are active-high.
- R2: No more than one bit of `gnt` is high in any cycle.
- R3: From one clock edge to the next, no more than one bit of `gnt` changes value.
- R4: While a grant is held and no master other than the holder has its request high, the grant stays unchanged on the next edge. This holds whether the holder is requesting or not, and whether the bus is busy or not.
- R5: While a grant is held and some other master has its request high, the whole grant vector is zero after the next edge.
- R6: The winner is fixed when the grant is removed. It is the first master with its request high, searching upward in index from the master after the previous holder, wrapping past the top index, with the previous holder examined last.
- R7: After a removal, the grant vector stays zero until an edge at which `busFrame` and `busIrdy` are both sampled low. The winner's grant is raised at that edge.
- R8: The grant that is raised after a removal goes to the stored winner. This is true even if the winner withdrew its request in the meantime or other masters started requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | Request line of each master, active high |
| busFrame | input | 1 | Bus frame signal, high while a transaction is framed |
| busIrdy | input | 1 | Initiator-ready signal, high while the initiator is in a data phase |
| gnt | output | NUM_MASTERS | Grant line of each master, active high, one-hot or all zero |

## Verification
The bench first applies an empty request vector and then a request from the current holder only, in both cases with the bus idle and with it busy. This separates correct parking from a spurious re-arbitration. Single and paired requests from other masters follow, placed on both sides of the holder's index, so that the ascending search and its wrap from the top index back to 0 each lead to a different winner. During a hand-over, the bench holds the bus busy with frame alone and then with initiator-ready alone. This shows that the idle test needs both signals low. It also swaps the request pattern during that wait, which shows whether the stored winner or a fresh pick gets the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Hand-over phase of the arbiter
  typedef enum logic {
    ST_HOLD    = 1'b0,   // a grant is asserted (or parked)
    ST_HANDOFF = 1'b1    // grant removed, winner waits for an idle bus
  } arbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic dropGnt;   // clear the grant vector and store the winner
    logic raiseGnt;  // assert the grant of the stored winner
  } arbStrb_t;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_MASTERS = 4,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]       lastIdx,
  output logic                   pickValid,
  output logic [IDX_W-1:0]       pickIdx
);

  // Rotated request vector: position k holds master (lastIdx + 1 + k) mod N,
  // so the holder itself lands in the last position and is examined last.
  logic [NUM_MASTERS-1:0] rotReq;
  logic [IDX_W-1:0]       rotIdx [NUM_MASTERS];

  for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_rot
    always_comb begin
      int sum;
      sum = int'(lastIdx) + 1 + k;
      if (sum >= NUM_MASTERS) sum = sum - NUM_MASTERS;
      rotIdx[k] = IDX_W'(sum);
      rotReq[k] = req[rotIdx[k]];
    end
  end

  // First set bit of the rotated vector wins
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = lastIdx;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      if (!pickValid && rotReq[k]) begin
        pickValid = 1'b1;
        pickIdx   = rotIdx[k];
      end
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] req,
  input  arbStrb_t               strb,
  output logic                   otherWins,
  output logic [NUM_MASTERS-1:0] gnt
);

  logic [IDX_W-1:0]       ownerIdx;
  logic                   pickValid;
  logic [IDX_W-1:0]       pickIdx;
  logic [NUM_MASTERS-1:0] gntQ;

  arb_rr_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .req       (req),
    .lastIdx   (ownerIdx),
    .pickValid (pickValid),
    .pickIdx   (pickIdx)
  );

  // A winner other than the holder means a hand-over is needed
  assign otherWins = pickValid && (pickIdx != ownerIdx);

  // ownerIdx names the most recent winner; it moves when the old grant drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx <= '0;
      gntQ     <= NUM_MASTERS'(1);
    end else if (strb.dropGnt) begin
      ownerIdx <= pickIdx;
      gntQ     <= '0;
    end else if (strb.raiseGnt) begin
      gntQ     <= NUM_MASTERS'(1) << ownerIdx;
    end
  end

  assign gnt = gntQ;

  // Winner stored at the drop is the one later raised (R8)
  assert_winner_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropGnt |=> (ownerIdx == $past(pickIdx)))
    else $error("stored winner lost");

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     otherWins,
  input  logic     busFrame,
  input  logic     busIrdy,
  output arbStrb_t strb
);

  arbState_t state, stateNxt;
  logic      busIdle;

  assign busIdle = !busFrame && !busIrdy;

  always_comb begin
    stateNxt      = state;
    strb.dropGnt  = 1'b0;
    strb.raiseGnt = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (otherWins) begin
          strb.dropGnt = 1'b1;
          stateNxt     = ST_HANDOFF;
        end
      end
      ST_HANDOFF: begin
        if (busIdle) begin
          strb.raiseGnt = 1'b1;
          stateNxt      = ST_HOLD;
        end
      end
      default: stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  // Raising only ever follows a removal, never two raises in a row (R3)
  assert_raise_after_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseGnt |=> !strb.raiseGnt)
    else $error("back-to-back raise");

  // A busy bus holds the hand-over state (R7)
  assert_wait_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HANDOFF && !busIdle) |=> (state == ST_HANDOFF))
    else $error("hand-over left while bus busy");

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   busFrame,
  input  logic                   busIrdy,
  output logic [NUM_MASTERS-1:0] gnt
);

  arbStrb_t strb;
  logic     otherWins;

  arb_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .otherWins (otherWins),
    .busFrame  (busFrame),
    .busIrdy   (busIrdy),
    .strb      (strb)
  );

  arb_datapath #(.NUM_MASTERS(NUM_MASTERS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .strb      (strb),
    .otherWins (otherWins),
    .gnt       (gnt)
  );

  assert_single_gnt_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt))
    else $error("two grants asserted");

  assert_one_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gnt ^ $past(gnt)) <= 1)
    else $error("more than one grant changed");

  assert_park_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((gnt != '0) && ((req & ~gnt) == '0)) |=> $stable(gnt))
    else $error("parked grant moved");

  assert_preempt_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((gnt != '0) && ((req & ~gnt) != '0)) |=> (gnt == '0))
    else $error("holder kept grant against another request");

  assert_rise_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((gnt & ~$past(gnt)) != '0) |-> ($past(busFrame) == 1'b0 && $past(busIrdy) == 1'b0))
    else $error("grant raised on busy bus");

endmodule

// File: tb/sim_bus_park_arbiter.sv
`timescale 1ns/100ps
module sim_bus_park_arbiter;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] req = '0;
  logic         busFrame = 1'b0;
  logic         busIrdy = 1'b0;
  logic [N-1:0] gnt;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #2.5 clk = ~clk;

  bus_park_arbiter #(.NUM_MASTERS(N)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .busFrame (busFrame),
    .busIrdy  (busIrdy),
    .gnt      (gnt)
  );

  task automatic checkGnt(input logic [N-1:0] exp, input string tag);
    total++;
    if (gnt !== exp) begin
      bad++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
  endtask

  // Driver: set inputs before an edge, queue the grant expected after it
  task automatic step(input logic [N-1:0] r, input logic f, input logic i,
                      input logic [N-1:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    req = r; busFrame = f; busIrdy = i;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checkGnt(cur.exp, cur.tag);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    checkGnt(4'b0001, "R1 reset park on master 0");

    step(4'b0000, 0, 0, 4'b0001, "R4 no requests, parked");
    step(4'b0001, 1, 1, 4'b0001, "R4 holder requests while busy");
    step(4'b0100, 1, 0, 4'b0000, "R5 master 2 requests, grant removed");
    step(4'b0100, 1, 0, 4'b0000, "R7 frame high holds hand-over");
    step(4'b1010, 0, 1, 4'b0000, "R7 irdy high alone holds hand-over");
    step(4'b1010, 0, 0, 4'b0100, "R8 stored winner 2 raised after withdrawal");
    step(4'b1010, 0, 0, 4'b0000, "R5 master 3 preempts 2");
    step(4'b0000, 0, 0, 4'b1000, "R6 search after 2 picks 3");
    step(4'b0000, 0, 0, 4'b1000, "R4 parked on 3");
    step(4'b0011, 0, 0, 4'b0000, "R5 masters 0,1 preempt 3");
    step(4'b0011, 0, 0, 4'b0001, "R6 wrap after 3 picks 0");
    step(4'b0011, 0, 0, 4'b0000, "R5 master 1 preempts 0");
    step(4'b0011, 0, 0, 4'b0010, "R6 rotation picks 1 over 0");
    step(4'b1001, 1, 1, 4'b0000, "R5 masters 0,3 preempt 1");
    step(4'b1001, 0, 0, 4'b1000, "R6 search after 1 picks 3 before 0");
    step(4'b1000, 1, 1, 4'b1000, "R4 holder 3 busy, no rival");
    step(4'b0000, 0, 0, 4'b1000, "R3 grant steady, single change rule");

    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule